// File: doc/BRIEF.md
# Double-Edge Burst Address-Phase Sequencer

This block sits inside one DMA channel and opens a single source-synchronous, double-edge burst on a parallel backplane bus. When told to start, it captures the channel's current bus address, its remaining byte count, the programmed block size, the address width choice (32 or 64 bits), the broadcast choice with its slave mask, and the channel's rate setting. It then walks the bus through three address phases, framed by the data strobe going active, inactive and active again. In each phase it presents the modifier, address, cycle-count and rate fields that belong to that phase.

The burst length is expressed in strobe cycles. Each cycle moves 8 bytes on each strobe edge, so one cycle carries 16 bytes. The length is cut back so that the burst neither runs over a 2 KB address boundary nor moves more bytes than the channel still owes. When the third phase is acknowledged, the block hands the bus to the data mover and waits for the mover to report that it has finished. A retry in the third phase replays the address phases unchanged. A bus error abandons the burst and raises a sticky error flag.

Top module: `sst_addr_seq`

## Requirements
- R1: After reset the block is idle: `phase`=0, `strobe`=0, `busy`=0, `xfer_go`=0, `done`=0 and `err_flag`=0.
- R2: One cycle after `start` in idle, `phase`=1 and `strobe`=1. In this phase `am_out`=0x20, and `addr_out` carries the captured address, with bits 63..32 forced to zero when `use_a64`=0.
- R3: In phase 1, `xam_out` is 0x11 for 32-bit unicast, 0x12 for 64-bit unicast, 0x21 for 32-bit broadcast and 0x22 for 64-bit broadcast.
- R4: In phase 2, `strobe`=0 and `rate_out` encodes the rate: `rate_sel` 0 gives 0 (slowest), 1 gives 1 (middle), and 2 or 3 gives 2 (fastest).
- R5: In phase 2, `count_out` equals min(block/16, (2048 − address mod 2048)/16, remaining/16), each term rounded down, and it is raised to 1 when that minimum is 0.
- R6: In phase 3, `strobe`=1. With broadcast on, `addr_out` bits 21..1 carry the slave mask and every other bit is 0. With broadcast off, `addr_out` repeats the phase-1 address.
- R7: Phases 1, 2 and 3 advance only on a cycle with `ack`=1. Without it the phase and its fields hold.
- R8: `retry` in phase 3 returns the block to phase 1 on the next cycle, with the same address and count.
- R9: `berr` in any busy state except the final one returns the block to idle on the next cycle and sets `err_flag`. The flag stays set until the next accepted `start` clears it. `berr` has priority over `retry` and `ack`.
- R10: `ack` in phase 3 sets `xfer_go`=1 until `mover_done`. After `mover_done`, `done` pulses for one cycle and the block then returns to idle. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst (accepted in idle only) |
| blk_bytes | input | CW | Programmed block size in bytes |
| remain_bytes | input | CW | Bytes still owed by the DMA channel |
| base_addr | input | AW | Current bus address |
| use_a64 | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| bcast_en | input | 1 | Broadcast write to several slaves |
| bcast_mask | input | GW | Bit i set selects slave at geographical address i+1 |
| rate_sel | input | 2 | Channel rate setting |
| ack | input | 1 | Bus acknowledge of the current phase |
| retry | input | 1 | Retry response in phase 3 |
| berr | input | 1 | Bus error |
| mover_done | input | 1 | Data mover finished the burst |
| strobe | output | 1 | Data strobe, 1 = asserted |
| phase | output | 2 | Current address phase, 0 when none |
| am_out | output | 6 | Address-modifier field |
| xam_out | output | 8 | Extended modifier field |
| addr_out | output | AW | Address field |
| count_out | output | CNTW | Burst cycle count (phase 2) |
| rate_out | output | 2 | Rate code (phase 2) |
| xfer_go | output | 1 | Data mover owns the bus |
| done | output | 1 | One-cycle burst completion pulse |
| busy | output | 1 | Burst in progress |
| err_flag | output | 1 | Sticky bus-error status |

## Verification
The main sweep runs address offsets across a whole 2 KB window, together with block sizes below, at and above the window and remaining counts from zero up to many windows. Whichever of the three limits is smallest must win, so the sweep separates a design that clips at the boundary from one that clips only at the block or remainder size. Offsets that are not 16-byte aligned and a zero remainder test the floor of 1. All four combinations of address width and broadcast are run, and a 64-bit address with non-zero upper bits shows whether those bits are masked in 32-bit mode. Directed runs cover stalls without acknowledge, a retry replay, a bus error, and a start issued while the block is busy.

// File: rtl/sst_addr_seq.sv
module sst_addr_seq #(
  parameter int AW = 64,
  parameter int CW = 24,
  parameter int BND_LOG = 11,
  parameter int BEAT_LOG = 4,
  parameter int GW = 21,
  localparam int CNTW = BND_LOG - BEAT_LOG + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   blk_bytes,
  input  logic [CW-1:0]   remain_bytes,
  input  logic [AW-1:0]   base_addr,
  input  logic            use_a64,
  input  logic            bcast_en,
  input  logic [GW-1:0]   bcast_mask,
  input  logic [1:0]      rate_sel,
  input  logic            ack,
  input  logic            retry,
  input  logic            berr,
  input  logic            mover_done,
  output logic            strobe,
  output logic [1:0]      phase,
  output logic [5:0]      am_out,
  output logic [7:0]      xam_out,
  output logic [AW-1:0]   addr_out,
  output logic [CNTW-1:0] count_out,
  output logic [1:0]      rate_out,
  output logic            xfer_go,
  output logic            done,
  output logic            busy,
  output logic            err_flag
);
  typedef enum logic [2:0] {S_IDLE, S_AP1, S_AP2, S_AP3, S_DATA, S_DONE} st_t;
  localparam logic [BND_LOG:0] BND = (BND_LOG+1)'(1) << BND_LOG;

  st_t st;
  logic [AW-1:0]   addr_q;
  logic [GW-1:0]   mask_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]      rate_q;
  logic            a64_q, bc_q;

  logic [BND_LOG:0] room;
  logic [CW-1:0]    room_b, blk_b, rem_b, m_a, m_b;
  logic [CNTW-1:0]  cnt_calc;

  assign room     = BND - {1'b0, base_addr[BND_LOG-1:0]};
  assign room_b   = CW'(room >> BEAT_LOG);
  assign blk_b    = blk_bytes >> BEAT_LOG;
  assign rem_b    = remain_bytes >> BEAT_LOG;
  assign m_a      = (blk_b < rem_b) ? blk_b : rem_b;
  assign m_b      = (m_a < room_b) ? m_a : room_b;
  assign cnt_calc = (m_b == '0) ? CNTW'(1) : m_b[CNTW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
      rate_q   <= '0;
      a64_q    <= 1'b0;
      bc_q     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st       <= S_AP1;
          addr_q   <= use_a64 ? base_addr : {{(AW-32){1'b0}}, base_addr[31:0]};
          mask_q   <= bcast_mask;
          cnt_q    <= cnt_calc;
          rate_q   <= (rate_sel == 2'd0) ? 2'd0 : (rate_sel == 2'd1) ? 2'd1 : 2'd2;
          a64_q    <= use_a64;
          bc_q     <= bcast_en;
          err_flag <= 1'b0;
        end
        S_AP1:  if (berr) begin st <= S_IDLE; err_flag <= 1'b1; end
                else if (ack) st <= S_AP2;
        S_AP2:  if (berr) begin st <= S_IDLE; err_flag <= 1'b1; end
                else if (ack) st <= S_AP3;
        S_AP3:  if (berr) begin st <= S_IDLE; err_flag <= 1'b1; end
                else if (retry) st <= S_AP1;
                else if (ack) st <= S_DATA;
        S_DATA: if (berr) begin st <= S_IDLE; err_flag <= 1'b1; end
                else if (mover_done) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign strobe    = (st == S_AP1) || (st == S_AP3);
  assign phase     = (st == S_AP1) ? 2'd1 : (st == S_AP2) ? 2'd2 : (st == S_AP3) ? 2'd3 : 2'd0;
  assign am_out    = (st == S_AP1) ? 6'h20 : 6'h00;
  assign xam_out   = (st == S_AP1) ? {2'b00, bc_q ? 2'b10 : 2'b01, 2'b00, a64_q ? 2'b10 : 2'b01} : 8'h00;
  assign addr_out  = (st == S_AP1 || st == S_AP2) ? addr_q :
                     (st == S_AP3) ? (bc_q ? AW'({mask_q, 1'b0}) : addr_q) : '0;
  assign count_out = (st == S_AP2) ? cnt_q : '0;
  assign rate_out  = (st == S_AP2) ? rate_q : 2'd0;
  assign xfer_go   = (st == S_DATA);
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);
endmodule

// File: rtl/sst_addr_seq_chk.sv
module sst_addr_seq_chk #(
  parameter int AW = 64,
  parameter int BND_LOG = 11,
  parameter int BEAT_LOG = 4,
  parameter int CNTW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            retry,
  input logic            berr,
  input logic [1:0]      phase,
  input logic            busy,
  input logic            done,
  input logic            err_flag,
  input logic [AW-1:0]   addr_out,
  input logic [CNTW-1:0] count_out
);
  AST_AP1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1 && ack && !berr) |=> (phase == 2'd2));  // R7
  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2) |-> (count_out != '0));  // R5
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && addr_out[BEAT_LOG-1:0] == '0) |->
    (32'(addr_out[BND_LOG-1:0]) + (32'(count_out) << BEAT_LOG) <= (32'd1 << BND_LOG)));  // R5
  AST_RETRY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && retry && !berr) |=> (phase == 2'd1));  // R8
  AST_BERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && berr) |=> (!busy && err_flag));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R10
endmodule

bind sst_addr_seq sst_addr_seq_chk #(.AW(AW), .BND_LOG(BND_LOG), .BEAT_LOG(BEAT_LOG), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .retry(retry), .berr(berr), .phase(phase),
  .busy(busy), .done(done), .err_flag(err_flag), .addr_out(addr_out), .count_out(count_out));

// File: tb/sim_sst_addr_seq.sv
module sim_sst_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] blk_bytes = '0, remain_bytes = '0;
  logic [63:0] base_addr = '0;
  logic use_a64 = 1'b0, bcast_en = 1'b0;
  logic [20:0] bcast_mask = '0;
  logic [1:0] rate_sel = '0;
  logic ack = 1'b0, retry = 1'b0, berr = 1'b0, mover_done = 1'b0;
  logic strobe, xfer_go, done, busy, err_flag;
  logic [1:0] phase, rate_out;
  logic [5:0] am_out;
  logic [7:0] xam_out, count_out;
  logic [63:0] addr_out;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sst_addr_seq u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int exp_cnt(input int blk, input int rem, input int off);
    int b = blk / 16, r = rem / 16, c = (2048 - off) / 16, m;
    m = (b < r) ? b : r;
    m = (m < c) ? m : c;
    return (m == 0) ? 1 : m;
  endfunction

  function automatic logic [63:0] exp_addr(input logic [63:0] a, input logic w64);
    return w64 ? a : {32'h0, a[31:0]};
  endfunction

  task automatic launch(input logic [63:0] a, input int blk, input int rem, input logic w64,
                        input logic bc, input logic [20:0] msk, input logic [1:0] rs);
    base_addr = a; blk_bytes = 24'(blk); remain_bytes = 24'(rem);
    use_a64 = w64; bcast_en = bc; bcast_mask = msk; rate_sel = rs;
    start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic full_run(input logic [63:0] a, input int blk, input int rem, input logic w64,
                          input logic bc, input logic [20:0] msk, input logic [1:0] rs, input logic stall);
    launch(a, blk, rem, w64, bc, msk, rs);
    chk("R2 phase1", phase, 1); chk("R2 strobe", strobe, 1); chk("R2 am", am_out, 6'h20);
    chk("R2 addr", addr_out, exp_addr(a, w64));
    chk("R3 xam", xam_out, {2'b0, bc ? 2'b10 : 2'b01, 2'b0, w64 ? 2'b10 : 2'b01});
    if (stall) begin tick(); chk("R7 hold ap1", phase, 1); end
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R4 phase2", phase, 2); chk("R4 strobe low", strobe, 0);
    chk("R4 rate", rate_out, (rs == 0) ? 0 : (rs == 1) ? 1 : 2);
    chk("R5 count", count_out, exp_cnt(blk, rem, int'(a[10:0])));
    if (stall) begin tick(); chk("R7 hold ap2", count_out, exp_cnt(blk, rem, int'(a[10:0]))); end
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R6 phase3", phase, 3); chk("R6 strobe", strobe, 1);
    chk("R6 addr", addr_out, bc ? {42'h0, msk, 1'b0} : exp_addr(a, w64));
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R10 xfer_go", xfer_go, 1);
    if (stall) begin tick(); chk("R10 wait mover", xfer_go, 1); end
    mover_done = 1'b1; tick(); mover_done = 1'b0;
    chk("R10 done", done, 1);
    tick();
    chk("R10 done pulse", done, 0); chk("R10 idle", busy, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 phase", phase, 0); chk("R1 busy", busy, 0); chk("R1 strobe", strobe, 0);
    chk("R1 err", err_flag, 0); chk("R1 go", xfer_go, 0);
    rst_n = 1'b1; tick();
    chk("R1 phase after release", phase, 0); chk("R1 done", done, 0);

    begin
      int blks[5] = '{8, 16, 256, 2048, 4096};
      int rems[4] = '{0, 40, 512, 30000};
      for (int off = 0; off < 2048; off += 112)
        for (int bi = 0; bi < 5; bi++)
          for (int ri = 0; ri < 4; ri++)
            full_run(64'hABCD_1234_0000_0000 + 64'(off) + 64'(bi * 2048), blks[bi], rems[ri],
                     bi[0], ri[0], 21'(off * 977 + ri), 2'(bi + ri), (off == 0) && (ri == 0));
    end
    full_run(64'h0000_0000_0000_07F8, 4096, 4096, 1'b0, 1'b0, '0, 2'd3, 1'b0);
    full_run(64'hFFFF_0000_1000_0400, 4096, 30000, 1'b0, 1'b1, 21'h1FFFFF, 2'd1, 1'b0);
    full_run(64'hFFFF_0000_1000_0400, 4096, 30000, 1'b1, 1'b0, 21'h000001, 2'd0, 1'b0);

    launch(64'h0000_0000_2000_0100, 2048, 2048, 1'b0, 1'b0, '0, 2'd1);
    ack = 1'b1; tick(); tick(); ack = 1'b0;
    retry = 1'b1; tick(); retry = 1'b0;
    chk("R8 back to ap1", phase, 1);
    chk("R8 same addr", addr_out, 64'h2000_0100);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R8 same count", count_out, 112);
    start = 1'b1; base_addr = 64'h5555; blk_bytes = 24'd16; tick(); start = 1'b0;
    chk("R10 start ignored phase", phase, 2);
    chk("R10 start ignored count", count_out, 112);
    berr = 1'b1; retry = 1'b1; ack = 1'b1; tick(); berr = 1'b0; retry = 1'b0; ack = 1'b0;
    chk("R9 idle", busy, 0); chk("R9 flag", err_flag, 1);
    tick(); chk("R9 flag sticky", err_flag, 1);
    launch(64'h40, 64, 64, 1'b0, 1'b0, '0, 2'd0);
    chk("R9 flag cleared", err_flag, 0);
    ack = 1'b1; tick(); tick(); tick(); ack = 1'b0;
    chk("R10 data", xfer_go, 1);
    berr = 1'b1; tick(); berr = 1'b0;
    chk("R9 data abort", busy, 0); chk("R9 data flag", err_flag, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule